// File: doc/BRIEF.md
# Oscillator-Paced Watchdog Timer with Register Port

This block is a watchdog for a processor subsystem. Software sets a timeout and then enables the timer. From then on a free-running slow oscillator sets the pace: each rising edge of the oscillator input is one tick, and each tick lowers a down-counter by one. To show it is still alive, software writes two fixed service words, in order, to the counter address. That reloads the counter. If the counter reaches zero and then takes one more tick, the block latches an event flag, pulses a reset request for one bus clock and reloads the counter.

Three protection bits guard the settings, each one above the last. While the timer is enabled, the timeout value and the run-in-mode bits cannot be changed. While write-protect is set, the enable bit cannot be changed. Once lock is set, write-protect and lock stay as they are until reset. Three system-state inputs (stop, wait, debug) can freeze the count unless software has allowed counting in that state. A 2-bit interrupt select raises an early-warning interrupt when the count falls below a fraction of the timeout.

The register port is a single-master, 16-bit classic bus slave with no back-pressure. A request is a cycle where `bus_cyc` and `bus_stb` are both high. `bus_ack` comes back for exactly one cycle, on the next clock. The master holds the request until it sees `bus_ack` and then drops `bus_stb`. A write takes effect at the same edge that raises `bus_ack`. Read data is valid while `bus_ack` is high.

Top module: `owdt_top`

## Requirements
- R1: After reset, control reads 0x0004 (enabled), timeout reads 0xFFFF, counter reads 0xFFFF, and `irq` and `rst_req` are low.
- R2: The register offsets are control 0, timeout 1 and counter 2. Offset 3 reads as zero. Control bits: [0] lock, [1] write-protect, [2] enable, [3] run in wait, [4] run in stop, [5] run in debug, [7:6] interrupt select, [8] event flag. Bits above 8 read zero. Every request gets a single-cycle ack on the next clock.
- R3: While enable is set, writes to the timeout register are ignored. So are writes to control bits [7:3], unless the same write clears enable, in which case those bits are written.
- R4: While write-protect is set, a control write leaves enable unchanged. Write-protect itself can be cleared while lock is clear.
- R5: Once lock is set, control writes change neither lock nor write-protect. Only reset clears them.
- R6: The counter register cannot be written as data. The service word 0x5555 followed by 0xAAAA, with no other counter write between them, makes the next tick reload the counter from the timeout. Any other counter write restarts the sequence.
- R7: The first tick after enable rises from 0 to 1 (or after reset) loads the timeout into the counter. Each later tick lowers the counter by one.
- R8: A tick that finds the counter at zero sets the event flag, reloads the counter from the timeout, and raises `rst_req` for exactly one clock.
- R9: The event flag is cleared by a control write with bit 8 set, or by a completed service sequence.
- R10: A tick has no effect while `stop_mode`, `wait_mode` or `debug_mode` is high and its run bit (4, 3 or 5 respectively) is clear.
- R11: With enable set and interrupt select s not zero, `irq` is high when count < T/4 (s=1), count < T/2 (s=2) or count < T/2+T/4 (s=3), where T is the timeout and each division rounds down.
- R12: Each rising edge of `osc_clk` is exactly one tick, however long the oscillator stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cyc | input | 1 | Bus cycle active |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_adr | input | 2 | Register offset |
| bus_wdat | input | 16 | Write data |
| bus_rdat | output | 16 | Read data, valid with ack |
| bus_ack | output | 1 | Single-cycle acknowledge |
| osc_clk | input | 1 | Slow oscillator, sampled by the bus clock |
| stop_mode | input | 1 | System in stop state |
| wait_mode | input | 1 | System in wait state |
| debug_mode | input | 1 | System in debug state |
| rst_req | output | 1 | One-clock reset request on expiry |
| irq | output | 1 | Early-warning interrupt |

## Verification
The assertions assume that the master issues one request at a time and drops `bus_stb` right after `bus_ack`. They also assume that `osc_clk` stays at each level for longer than the synchronizer depth plus one bus clock, so that each oscillator edge becomes one single-cycle tick. The stimulus meets these assumptions by construction. Its bus tasks release the strobe in the cycle that carries the ack. Its oscillator task holds each level for at least four bus clocks. It sets the stop, wait and debug inputs before an oscillator edge and holds them until after the tick that edge produces, so the freeze condition is stable around every tick.

// File: rtl/owdt_pkg.sv
`timescale 1ns/1ps
package owdt_pkg;
  // control bit positions (software decodes these)
  localparam int B_LOCK   = 0;
  localparam int B_WP     = 1;
  localparam int B_EN     = 2;
  localparam int B_RUN_LO = 3;
  localparam int B_SEL_LO = 6;
  localparam int B_EVT    = 8;
  localparam int CTRL_BITS = 9;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TOUT = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // order matches control bits [5:3]
  typedef struct packed {
    logic in_dbg;
    logic in_stop;
    logic in_wait;
  } run_en_t;

  typedef enum logic {
    SVC_IDLE = 1'b0,
    SVC_HALF = 1'b1
  } svc_st_e;
endpackage

// File: rtl/owdt_tick_sync.sv
`timescale 1ns/1ps
module owdt_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic tick
);
  localparam int W = STAGES + 1;

  logic [W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[W-2:0], async_in};
  end

  // rising edge seen past the synchronizer stages
  assign tick = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R12
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/owdt_regs.sv
`timescale 1ns/1ps
module owdt_regs import owdt_pkg::*; #(
  parameter int            DW       = 16,
  parameter logic [DW-1:0] TOUT_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_tout,
  input  logic [DW-1:0] wdat,
  output logic          lock,
  output logic          wprot,
  output logic          en,
  output run_en_t       run,
  output logic [1:0]    sel,
  output logic [DW-1:0] tout,
  output logic          en_set
);
  logic          lock_q, wp_q, en_q;
  run_en_t       run_q;
  logic [1:0]    sel_q;
  logic [DW-1:0] tout_q;
  logic          en_nxt;
  logic          cfg_open;

  // enable follows the write only when write-protect is clear
  assign en_nxt   = wp_q ? en_q : wdat[B_EN];
  // config writable while disabled, or by the write that disables
  assign cfg_open = !en_q || !en_nxt;
  assign en_set   = wr_ctrl && !en_q && en_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      wp_q   <= 1'b0;
      en_q   <= 1'b1;
      run_q  <= '0;
      sel_q  <= '0;
      tout_q <= TOUT_RST;
    end else begin
      if (wr_ctrl) begin
        if (!lock_q) begin
          lock_q <= wdat[B_LOCK];
          wp_q   <= wdat[B_WP];
        end
        en_q <= en_nxt;
        if (cfg_open) begin
          run_q <= run_en_t'(wdat[B_RUN_LO+2:B_RUN_LO]);
          sel_q <= wdat[B_SEL_LO+1:B_SEL_LO];
        end
      end
      if (wr_tout && !en_q) tout_q <= wdat;
    end
  end

  assign lock  = lock_q;
  assign wprot = wp_q;
  assign en    = en_q;
  assign run   = run_q;
  assign sel   = sel_q;
  assign tout  = tout_q;

  // R3
  tout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> $stable(tout_q));
  // R4
  en_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q |=> $stable(en_q));
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  // R5
  wp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(wp_q));
endmodule

// File: rtl/owdt_service.sv
`timescale 1ns/1ps
module owdt_service import owdt_pkg::*; #(
  parameter int            DW        = 16,
  parameter logic [DW-1:0] SVC_WORD0 = 'h5555,
  parameter logic [DW-1:0] SVC_WORD1 = 'hAAAA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cnt,
  input  logic [DW-1:0] wdat,
  output logic          svc_ok
);
  svc_st_e st_q;

  assign svc_ok = wr_cnt && (st_q == SVC_HALF) && (wdat == SVC_WORD1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SVC_IDLE;
    else if (wr_cnt) begin
      if (st_q == SVC_IDLE && wdat == SVC_WORD0) st_q <= SVC_HALF;
      else                                       st_q <= SVC_IDLE;
    end
  end

  // R6
  svc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    svc_ok |=> (st_q == SVC_IDLE));
endmodule

// File: rtl/owdt_counter.sv
`timescale 1ns/1ps
module owdt_counter import owdt_pkg::*; #(
  parameter int            DW      = 16,
  parameter logic [DW-1:0] CNT_RST = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  run_en_t       run,
  input  logic          stop_mode,
  input  logic          wait_mode,
  input  logic          debug_mode,
  input  logic [DW-1:0] tout,
  input  logic [1:0]    sel,
  input  logic          reload_req,
  input  logic          evt_clr,
  output logic [DW-1:0] cnt,
  output logic          evt,
  output logic          rst_req,
  output logic          irq
);
  logic [DW-1:0] cnt_q;
  logic          pend_q, evt_q, rst_q;
  logic          hold, step, expire;
  logic [DW-1:0] q1, q2, q3, thr;

  assign hold   = (stop_mode  && !run.in_stop) ||
                  (wait_mode  && !run.in_wait) ||
                  (debug_mode && !run.in_dbg);
  assign step   = tick && en && !hold;
  assign expire = step && !pend_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= CNT_RST;
      pend_q <= 1'b1;
      evt_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= expire;
      if (reload_req) pend_q <= 1'b1;
      else if (step)  pend_q <= 1'b0;
      if (step) cnt_q <= (pend_q || cnt_q == '0) ? tout : cnt_q - 1'b1;
      if (expire)       evt_q <= 1'b1;
      else if (evt_clr) evt_q <= 1'b0;
    end
  end

  // early-warning thresholds: quarter, half, three quarters
  assign q1 = tout >> 2;
  assign q2 = tout >> 1;
  assign q3 = q1 + q2;

  always_comb begin
    unique case (sel)
      2'd1:    thr = q1;
      2'd2:    thr = q2;
      2'd3:    thr = q3;
      default: thr = '0;
    endcase
  end

  assign irq     = en && (sel != 2'd0) && (cnt_q < thr);
  assign cnt     = cnt_q;
  assign evt     = evt_q;
  assign rst_req = rst_q;

  // R8
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q);
  // R8
  evt_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> evt_q);
  // R10
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(cnt_q));
endmodule

// File: rtl/owdt_top.sv
`timescale 1ns/1ps
module owdt_top import owdt_pkg::*; #(
  parameter int            DW          = 16,
  parameter logic [DW-1:0] SVC_WORD0   = 'h5555,
  parameter logic [DW-1:0] SVC_WORD1   = 'hAAAA,
  parameter logic [DW-1:0] TOUT_RST    = '1,
  parameter int            SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cyc,
  input  logic          bus_stb,
  input  logic          bus_we,
  input  logic [1:0]    bus_adr,
  input  logic [DW-1:0] bus_wdat,
  output logic [DW-1:0] bus_rdat,
  output logic          bus_ack,
  input  logic          osc_clk,
  input  logic          stop_mode,
  input  logic          wait_mode,
  input  logic          debug_mode,
  output logic          rst_req,
  output logic          irq
);
  logic          req, wr, ack_q;
  logic [DW-1:0] rdat_q, ctrl_rd;
  reg_sel_e      rsel;
  logic          wr_ctrl, wr_tout, wr_cnt;
  logic          lock, wprot, en, en_set, svc_ok, tick, evt;
  run_en_t       run;
  logic [1:0]    sel;
  logic [DW-1:0] tout, cnt;

  assign req     = bus_cyc && bus_stb && !ack_q;
  assign wr      = req && bus_we;
  assign rsel    = reg_sel_e'(bus_adr);
  assign wr_ctrl = wr && (rsel == REG_CTRL);
  assign wr_tout = wr && (rsel == REG_TOUT);
  assign wr_cnt  = wr && (rsel == REG_CNT);

  owdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(osc_clk), .tick(tick)
  );

  owdt_regs #(.DW(DW), .TOUT_RST(TOUT_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_tout(wr_tout),
    .wdat(bus_wdat), .lock(lock), .wprot(wprot), .en(en), .run(run),
    .sel(sel), .tout(tout), .en_set(en_set)
  );

  owdt_service #(.DW(DW), .SVC_WORD0(SVC_WORD0), .SVC_WORD1(SVC_WORD1)) u_svc (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wdat(bus_wdat), .svc_ok(svc_ok)
  );

  owdt_counter #(.DW(DW), .CNT_RST('1)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .en(en), .run(run),
    .stop_mode(stop_mode), .wait_mode(wait_mode), .debug_mode(debug_mode),
    .tout(tout), .sel(sel), .reload_req(en_set || svc_ok),
    .evt_clr((wr_ctrl && bus_wdat[B_EVT]) || svc_ok),
    .cnt(cnt), .evt(evt), .rst_req(rst_req), .irq(irq)
  );

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[B_LOCK] = lock;
    ctrl_rd[B_WP]   = wprot;
    ctrl_rd[B_EN]   = en;
    ctrl_rd[B_RUN_LO+2:B_RUN_LO] = run;
    ctrl_rd[B_SEL_LO+1:B_SEL_LO] = sel;
    ctrl_rd[B_EVT]  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
    end else begin
      ack_q <= req;
      if (req) begin
        unique case (rsel)
          REG_CTRL: rdat_q <= ctrl_rd;
          REG_TOUT: rdat_q <= tout;
          REG_CNT:  rdat_q <= cnt;
          default:  rdat_q <= '0;
        endcase
      end
    end
  end

  assign bus_ack  = ack_q;
  assign bus_rdat = rdat_q;

  // R2
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);
endmodule

// File: tb/owdt_top_tb_top.sv
`timescale 1ns/1ps
module owdt_top_tb_top;
  localparam logic [15:0] W0 = 16'h5555;
  localparam logic [15:0] W1 = 16'hAAAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cyc = 1'b0, bus_stb = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_adr = 2'd0;
  logic [15:0] bus_wdat = 16'h0;
  logic [15:0] bus_rdat;
  logic        bus_ack;
  logic        osc_clk = 1'b0;
  logic        stop_mode = 1'b0, wait_mode = 1'b0, debug_mode = 1'b0;
  logic        rst_req, irq;

  always #2 clk = ~clk;

  owdt_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
    .bus_we(bus_we), .bus_adr(bus_adr), .bus_wdat(bus_wdat),
    .bus_rdat(bus_rdat), .bus_ack(bus_ack), .osc_clk(osc_clk),
    .stop_mode(stop_mode), .wait_mode(wait_mode), .debug_mode(debug_mode),
    .rst_req(rst_req), .irq(irq)
  );

  int n_chk = 0;
  int n_bad = 0;
  int rst_seen = 0;
  int m_exp = 0;

  always @(negedge clk) if (rst_req) rst_seen++;

  // reference model state
  logic        m_lock, m_wp, m_en, m_pend, m_seq, m_evt;
  logic [2:0]  m_run;
  logic [1:0]  m_sel;
  logic [15:0] m_tout, m_cnt;

  function automatic logic [15:0] m_ctrl();
    return {7'b0, m_evt, m_sel, m_run, m_en, m_wp, m_lock};
  endfunction

  function automatic logic m_irq();
    logic [15:0] t;
    case (m_sel)
      2'd1:    t = m_tout >> 2;
      2'd2:    t = m_tout >> 1;
      2'd3:    t = (m_tout >> 2) + (m_tout >> 1);
      default: t = 16'h0;
    endcase
    return m_en && (m_sel != 2'd0) && (m_cnt < t);
  endfunction

  task automatic model_reset();
    m_lock = 0; m_wp = 0; m_en = 1; m_pend = 1; m_seq = 0; m_evt = 0;
    m_run = 0; m_sel = 0; m_tout = 16'hFFFF; m_cnt = 16'hFFFF;
  endtask

  task automatic model_wr(input logic [1:0] a, input logic [15:0] d);
    logic en_n;
    case (a)
      2'd0: begin
        en_n = m_wp ? m_en : d[2];
        if (!m_en || !en_n) begin m_run = d[5:3]; m_sel = d[7:6]; end
        if (!m_en && en_n) m_pend = 1;
        if (!m_lock) begin m_lock = d[0]; m_wp = d[1]; end
        if (d[8]) m_evt = 0;
        m_en = en_n;
      end
      2'd1: if (!m_en) m_tout = d;
      2'd2: begin
        if (!m_seq) m_seq = (d == W0);
        else begin
          if (d == W1) begin m_pend = 1; m_evt = 0; end
          m_seq = 0;
        end
      end
      default: ;
    endcase
  endtask

  task automatic model_tick(input logic st, input logic wt, input logic dg);
    logic hold;
    hold = (st && !m_run[1]) || (wt && !m_run[0]) || (dg && !m_run[2]);
    if (m_en && !hold) begin
      if (m_pend) begin m_cnt = m_tout; m_pend = 0; end
      else if (m_cnt == 16'h0) begin m_evt = 1; m_exp++; m_cnt = m_tout; end
      else m_cnt = m_cnt - 16'h1;
    end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 1; bus_adr = a; bus_wdat = d;
    @(negedge clk);
    bus_cyc = 0; bus_stb = 0; bus_we = 0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_cyc = 1; bus_stb = 1; bus_we = 0; bus_adr = a;
    @(negedge clk);
    d = bus_rdat;
    bus_cyc = 0; bus_stb = 0;
  endtask

  task automatic osc_tick(input logic st, input logic wt, input logic dg, input int hi);
    @(negedge clk);
    stop_mode = st; wait_mode = wt; debug_mode = dg; osc_clk = 1;
    repeat (hi) @(negedge clk);
    osc_clk = 0;
    repeat (4) @(negedge clk);
    stop_mode = 0; wait_mode = 0; debug_mode = 0;
    model_tick(st, wt, dg);
  endtask

  task automatic tk();
    osc_tick(0, 0, 0, 4);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; osc_clk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic verify(input string req);
    logic [15:0] v;
    rd(2'd0, v); chk(req, "ctrl", v, m_ctrl());
    rd(2'd1, v); chk(req, "timeout", v, m_tout);
    rd(2'd2, v); chk(req, "counter", v, m_cnt);
    chk(req, "irq", {15'b0, irq}, {15'b0, m_irq()});
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int seed;
    seed = int'($urandom(32'h00C0FFEE));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    rd(2'd0, v); chk("R1", "ctrl", v, 16'h0004);
    rd(2'd1, v); chk("R1", "timeout", v, 16'hFFFF);
    rd(2'd2, v); chk("R1", "counter", v, 16'hFFFF);
    chk("R1", "irq/rst_req", {14'b0, irq, rst_req}, 16'h0);
    // R2 unused offset
    rd(2'd3, v); chk("R2", "offset 3", v, 16'h0000);

    // R3 config frozen while enabled
    wr(2'd1, 16'h1234); rd(2'd1, v); chk("R3", "timeout locked", v, 16'hFFFF);
    wr(2'd0, 16'h003C); rd(2'd0, v); chk("R3", "modes locked", v, 16'h0004);
    wr(2'd0, 16'h0038); rd(2'd0, v); chk("R3", "disable write", v, 16'h0038);
    wr(2'd0, 16'h0000); wr(2'd1, 16'h0005);
    rd(2'd1, v); chk("R3", "timeout open", v, 16'h0005);

    // R7 load then decrement, R12 one tick per edge
    wr(2'd0, 16'h0004);
    tk(); rd(2'd2, v); chk("R7", "load", v, 16'h0005);
    tk(); tk(); rd(2'd2, v); chk("R7", "decrement", v, 16'h0003);
    osc_tick(0, 0, 0, 20); rd(2'd2, v); chk("R12", "long high", v, 16'h0002);

    // R6 counter read-only and service sequence
    wr(2'd2, 16'h0000); rd(2'd2, v); chk("R6", "read-only", v, 16'h0002);
    wr(2'd2, W0); wr(2'd2, W1); tk();
    rd(2'd2, v); chk("R6", "service reload", v, 16'h0005);
    wr(2'd2, W0); wr(2'd2, 16'h1111); wr(2'd2, W1); tk();
    rd(2'd2, v); chk("R6", "broken sequence", v, 16'h0004);

    // R8 expiry
    repeat (4) tk();
    rd(2'd2, v); chk("R8", "at zero", v, 16'h0000);
    tk();
    rd(2'd0, v); chk("R8", "event flag", v, 16'h0104);
    rd(2'd2, v); chk("R8", "reload", v, 16'h0005);
    chk("R8", "reset pulses", 16'(rst_seen), 16'd1);

    // R9 clears
    wr(2'd0, 16'h0104); rd(2'd0, v); chk("R9", "write-one clear", v, 16'h0004);
    repeat (6) tk();
    rd(2'd0, v); chk("R9", "second expiry", v, 16'h0104);
    wr(2'd2, W0); wr(2'd2, W1);
    rd(2'd0, v); chk("R9", "service clear", v, 16'h0004);

    // R4 write-protect holds enable
    wr(2'd0, 16'h0006); rd(2'd0, v); chk("R4", "set wp", v, 16'h0006);
    wr(2'd0, 16'h0002); rd(2'd0, v); chk("R4", "en held", v, 16'h0006);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R4", "wp cleared", v, 16'h0004);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R4", "en cleared", v, 16'h0000);

    // R5 lock
    wr(2'd0, 16'h0003); rd(2'd0, v); chk("R5", "set lock", v, 16'h0003);
    wr(2'd0, 16'h0000); rd(2'd0, v); chk("R5", "frozen", v, 16'h0003);
    do_reset(); rd(2'd0, v); chk("R5", "reset clears", v, 16'h0004);

    // R10 mode freeze
    wr(2'd0, 16'h0000); wr(2'd1, 16'd10); wr(2'd0, 16'h0014);
    tk(); rd(2'd2, v); chk("R10", "load", v, 16'd10);
    osc_tick(1, 0, 0, 4); rd(2'd2, v); chk("R10", "stop allowed", v, 16'd9);
    osc_tick(0, 1, 0, 4); rd(2'd2, v); chk("R10", "wait frozen", v, 16'd9);
    osc_tick(0, 0, 1, 4); rd(2'd2, v); chk("R10", "debug frozen", v, 16'd9);
    tk(); rd(2'd2, v); chk("R10", "resumed", v, 16'd8);

    // R11 three-quarter threshold, T=8 -> below 6
    wr(2'd0, 16'h0000); wr(2'd1, 16'd8); wr(2'd0, 16'h00C4);
    tk(); chk("R11", "irq at 8", {15'b0, irq}, 16'h0);
    tk(); tk(); chk("R11", "irq at 6", {15'b0, irq}, 16'h0);
    tk(); chk("R11", "irq at 5", {15'b0, irq}, 16'h1);
    wr(2'd0, 16'h0000); chk("R11", "irq off", {15'b0, irq}, 16'h0);

    // constrained random phase
    for (int i = 0; i < 800; i++) begin
      int op;
      logic [15:0] d;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: begin
          d = 16'($urandom) & 16'h01FE;
          if ($urandom_range(0, 19) == 0) d[0] = 1'b1;
          wr(2'd0, d);
        end
        2: begin
          d = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'($urandom_range(0, 11));
          wr(2'd1, d);
        end
        3: begin wr(2'd2, W0); wr(2'd2, W1); end
        4: begin wr(2'd2, W0); wr(2'd2, 16'($urandom)); end
        5: wr(2'd2, 16'($urandom));
        9: if ($urandom_range(0, 7) == 0) do_reset(); else tk();
        default: osc_tick($urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
                          $urandom_range(0, 3) == 0, 4);
      endcase
      verify("R2 random");
    end
    chk("R8", "total reset pulses", 16'(rst_seen), 16'(m_exp));

    summary();
    $finish;
  end
endmodule